// File: doc/BRIEF.md
# Triangle Coverage Walker

This block turns one screen-space triangle into a stream of covered pixels. Each vertex arrives as a signed fixed-point coordinate pair with four fractional bits. When a triangle is accepted, a setup stage does the following:

- finds the winding and the doubled signed area;
- builds the pixel rectangle that encloses the triangle and clips it to the screen;
- evaluates the three edge functions once, at the centre of the rectangle's top-left pixel.

A walker then visits every pixel of the rectangle, one per clock. It moves along a row by subtracting a fixed per-edge constant. It moves to the next row by adding a second constant to a saved row-start value. Multipliers are used only during setup.

Each covered pixel leaves as a fragment. A fragment carries its pixel coordinates and two unnormalised barycentric weights. The third weight is the doubled area minus the two weights sent. Scaling by the inverse area is left to a later stage. Triangles enter through a valid/ready handshake, and fragments leave through a second one. A one-cycle completion pulse ends every accepted triangle, including triangles that are dropped.

Top module: `tri_raster`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `tri_done` is 0.
- R2: A pixel (x,y) is emitted exactly when all three edge values at its centre (16x+8, 16y+8) in subpixel units are strictly positive. The edges are A→B, B→C and C→A, with E(U,V,P) = (P.x−U.x)(V.y−U.y) − (P.y−U.y)(V.x−U.x). A centre lying exactly on an edge is not emitted.
- R3: Fragments of one triangle leave in row-major order: y ascending, and x ascending within a row, over the clipped bounding rectangle.
- R4: `out_w0` equals E(B,C,P) and `out_w1` equals E(C,A,P), taken at the pixel centre P for the vertices after any winding swap. Their sum is below the doubled area.
- R5: The rectangle is the vertex extent, floored to whole pixels and clamped to 0..SCR_W−1 and 0..SCR_H−1. A triangle lying wholly off screen emits nothing.
- R6: A triangle with zero doubled area E(A,B,C) emits no fragment. Its `tri_done` pulse comes in the cycle after acceptance.
- R7: When E(A,B,C) < 0 and `cull_neg` = 1, the triangle is dropped. When `cull_neg` = 0, B and C are swapped, and the fragments are those of the triangle A,C,B.
- R8: While `out_valid` = 1 and `out_ready` = 0, the fragment stays unchanged and no pixel is skipped.
- R9: `tri_done` is a single-cycle pulse, once per accepted triangle, that comes after the triangle's last fragment. `in_ready` is 0 while a walk is in progress and 1 when `tri_done` is raised.
- R10: Fractional vertex bits affect coverage. Rectangle and coverage follow the full subpixel coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Triangle offered |
| in_ready | output | 1 | Walker idle, triangle can be taken |
| in_ax | input | VW | Vertex A x, signed, 4 fractional bits |
| in_ay | input | VW | Vertex A y |
| in_bx | input | VW | Vertex B x |
| in_by | input | VW | Vertex B y |
| in_cx | input | VW | Vertex C x |
| in_cy | input | VW | Vertex C y |
| cull_neg | input | 1 | 1: drop negative-area triangles; 0: swap their winding |
| out_valid | output | 1 | Fragment present |
| out_ready | input | 1 | Fragment consumer ready |
| out_x | output | $clog2(SCR_W) | Fragment pixel column |
| out_y | output | $clog2(SCR_H) | Fragment pixel row |
| out_w0 | output | 2*VW+4 | Edge value B→C at pixel centre (weight of A) |
| out_w1 | output | 2*VW+4 | Edge value C→A at pixel centre (weight of B) |
| tri_done | output | 1 | One-cycle end-of-triangle pulse |

## Verification
The bench targets the cases where an incremental walker usually goes wrong:

- **Centres exactly on an edge.** A vertical edge at x = 8.5 pixels must exclude that column. A design testing for ≥ 0 would emit an extra column.
- **Vertices with fractional bits.** A design that truncated vertices to whole pixels would mis-place the boundary.
- **Reversed winding in both modes.** Flip mode must yield exactly the swapped triangle's fragments and weights. Cull mode must yield none.
- **Triangles hanging past every screen side, and one entirely off screen.** An unclamped rectangle would emit out-of-range columns, or wrap the coordinates.
- **A throttled consumer.** A walker that advanced during a stall would lose fragments or change them mid-handshake.
- **The row step.** A wrong row step shows up as weight mismatches from the second row onward.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;
endpackage

// File: rtl/tri_raster_setup.sv
module tri_raster_setup #(
    parameter int VW    = 12,
    parameter int SCR_W = 32,
    parameter int SCR_H = 32,
    parameter int EW    = 2 * VW + 4,
    parameter int XW    = $clog2(SCR_W),
    parameter int YW    = $clog2(SCR_H)
) (
    input  logic signed [VW-1:0] ax,
    input  logic signed [VW-1:0] ay,
    input  logic signed [VW-1:0] bx,
    input  logic signed [VW-1:0] by,
    input  logic signed [VW-1:0] cx,
    input  logic signed [VW-1:0] cy,
    input  logic                 cull_neg,
    output logic                 keep,
    output logic                 zero_area,
    output logic [XW-1:0]        minx,
    output logic [XW-1:0]        maxx,
    output logic [YW-1:0]        miny,
    output logic [YW-1:0]        maxy,
    output logic signed [EW-1:0] area,
    output logic signed [EW-1:0] e_init [3],
    output logic signed [EW-1:0] step_x [3],
    output logic signed [EW-1:0] step_y [3]
);
    localparam logic signed [VW-1:0] XLIM = VW'(SCR_W - 1);
    localparam logic signed [VW-1:0] YLIM = VW'(SCR_H - 1);

    function automatic logic signed [EW-1:0] edge_val(
        input logic signed [EW-1:0] ux, uy, vx, vy, px, py);
        return (px - ux) * (vy - uy) - (py - uy) * (vx - ux);
    endfunction

    logic signed [EW-1:0] wax, way, wbx, wby, wcx, wcy;
    logic signed [EW-1:0] area_raw;
    logic                 neg;
    logic signed [EW-1:0] vx [3];
    logic signed [EW-1:0] vy [3];
    logic signed [VW-1:0] lo_x, hi_x, lo_y, hi_y;
    logic signed [VW-1:0] cl_lo_x, cl_hi_x, cl_lo_y, cl_hi_y;
    logic                 onscreen;
    logic signed [EW-1:0] px0, py0;

    assign wax = ax;
    assign way = ay;
    assign wbx = bx;
    assign wby = by;
    assign wcx = cx;
    assign wcy = cy;

    always_comb begin
        area_raw  = edge_val(wax, way, wbx, wby, wcx, wcy);
        neg       = area_raw < 0;
        area      = neg ? -area_raw : area_raw;
        zero_area = (area_raw == 0);
        vx[0] = wax;              vy[0] = way;
        vx[1] = neg ? wcx : wbx;  vy[1] = neg ? wcy : wby;
        vx[2] = neg ? wbx : wcx;  vy[2] = neg ? wby : wcy;
    end

    always_comb begin
        lo_x = (ax < bx) ? ax : bx;
        lo_x = (cx < lo_x) ? cx : lo_x;
        hi_x = (ax > bx) ? ax : bx;
        hi_x = (cx > hi_x) ? cx : hi_x;
        lo_y = (ay < by) ? ay : by;
        lo_y = (cy < lo_y) ? cy : lo_y;
        hi_y = (ay > by) ? ay : by;
        hi_y = (cy > hi_y) ? cy : hi_y;
        lo_x = lo_x >>> 4;
        hi_x = hi_x >>> 4;
        lo_y = lo_y >>> 4;
        hi_y = hi_y >>> 4;
        onscreen = !(hi_x < 0) && !(lo_x > XLIM) && !(hi_y < 0) && !(lo_y > YLIM);
        cl_lo_x = (lo_x < 0) ? '0 : lo_x;
        cl_hi_x = (hi_x > XLIM) ? XLIM : hi_x;
        cl_lo_y = (lo_y < 0) ? '0 : lo_y;
        cl_hi_y = (hi_y > YLIM) ? YLIM : hi_y;
        minx = cl_lo_x[XW-1:0];
        maxx = cl_hi_x[XW-1:0];
        miny = cl_lo_y[YW-1:0];
        maxy = cl_hi_y[YW-1:0];
        keep = !zero_area && !(neg && cull_neg) && onscreen;
        px0  = $signed({{(EW-XW-4){1'b0}}, minx, 4'b1000});
        py0  = $signed({{(EW-YW-4){1'b0}}, miny, 4'b1000});
    end

    for (genvar k = 0; k < 3; k++) begin : g_edge
        localparam int K1 = (k + 1) % 3;
        assign e_init[k] = edge_val(vx[k], vy[k], vx[K1], vy[K1], px0, py0);
        assign step_x[k] = (vy[k] - vy[K1]) <<< 4;
        assign step_y[k] = (vx[k] - vx[K1]) <<< 4;
    end
endmodule

// File: rtl/tri_raster_walk.sv
module tri_raster_walk
    import tri_raster_pkg::*;
#(
    parameter int EW = 28,
    parameter int XW = 5,
    parameter int YW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 drop,
    input  logic [XW-1:0]        minx,
    input  logic [XW-1:0]        maxx,
    input  logic [YW-1:0]        miny,
    input  logic [YW-1:0]        maxy,
    input  logic signed [EW-1:0] area,
    input  logic signed [EW-1:0] e_init [3],
    input  logic signed [EW-1:0] step_x [3],
    input  logic signed [EW-1:0] step_y [3],
    output logic                 idle,
    output logic                 frag_valid,
    input  logic                 frag_ready,
    output logic [XW-1:0]        frag_x,
    output logic [YW-1:0]        frag_y,
    output logic signed [EW-1:0] frag_w0,
    output logic signed [EW-1:0] frag_w1,
    output logic                 done
);
    typedef struct packed {
        walk_st_e           st;
        logic [XW-1:0]      x;
        logic [YW-1:0]      y;
        logic [XW-1:0]      minx;
        logic [XW-1:0]      maxx;
        logic [YW-1:0]      maxy;
        logic [EW-1:0]      area;
        logic [2:0][EW-1:0] erow;
        logic [2:0][EW-1:0] ecol;
        logic [2:0][EW-1:0] sx;
        logic [2:0][EW-1:0] sy;
        logic               done;
    } walk_t;

    walk_t r_d, r_q;
    logic  cov_q;

    always_comb begin
        cov_q = ($signed(r_q.erow[0]) > 0) && ($signed(r_q.erow[1]) > 0)
             && ($signed(r_q.erow[2]) > 0);
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_WALK;
                    r_d.x    = minx;
                    r_d.y    = miny;
                    r_d.minx = minx;
                    r_d.maxx = maxx;
                    r_d.maxy = maxy;
                    r_d.area = area;
                    for (int k = 0; k < 3; k++) begin
                        r_d.erow[k] = e_init[k];
                        r_d.ecol[k] = e_init[k];
                        r_d.sx[k]   = step_x[k];
                        r_d.sy[k]   = step_y[k];
                    end
                end else if (drop) begin
                    r_d.done = 1'b1;
                end
            end
            default: begin
                if (!cov_q || frag_ready) begin
                    if (r_q.x == r_q.maxx) begin
                        if (r_q.y == r_q.maxy) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.y = r_q.y + 1'b1;
                            r_d.x = r_q.minx;
                            for (int k = 0; k < 3; k++) begin
                                r_d.ecol[k] = r_q.ecol[k] + r_q.sy[k];
                                r_d.erow[k] = r_q.ecol[k] + r_q.sy[k];
                            end
                        end
                    end else begin
                        r_d.x = r_q.x + 1'b1;
                        for (int k = 0; k < 3; k++)
                            r_d.erow[k] = r_q.erow[k] - r_q.sx[k];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign idle       = (r_q.st == ST_IDLE);
    assign frag_valid = (r_q.st == ST_WALK) && cov_q;
    assign frag_x     = r_q.x;
    assign frag_y     = r_q.y;
    assign frag_w0    = $signed(r_q.erow[1]);
    assign frag_w1    = $signed(r_q.erow[2]);
    assign done       = r_q.done;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid && !frag_ready |=> frag_valid && $stable(frag_x) && $stable(frag_y)
            && $stable(frag_w0) && $stable(frag_w1));
    p_inbox_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (frag_x >= r_q.minx) && (frag_x <= r_q.maxx) && (frag_y <= r_q.maxy));
    p_wsum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (frag_w0 + frag_w1) < $signed(r_q.area));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/tri_raster.sv
module tri_raster #(
    parameter int VW    = 12,
    parameter int SCR_W = 32,
    parameter int SCR_H = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [VW-1:0]      in_ax,
    input  logic signed [VW-1:0]      in_ay,
    input  logic signed [VW-1:0]      in_bx,
    input  logic signed [VW-1:0]      in_by,
    input  logic signed [VW-1:0]      in_cx,
    input  logic signed [VW-1:0]      in_cy,
    input  logic                      cull_neg,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [$clog2(SCR_W)-1:0]  out_x,
    output logic [$clog2(SCR_H)-1:0]  out_y,
    output logic signed [2*VW+3:0]    out_w0,
    output logic signed [2*VW+3:0]    out_w1,
    output logic                      tri_done
);
    localparam int EW = 2 * VW + 4;
    localparam int XW = $clog2(SCR_W);
    localparam int YW = $clog2(SCR_H);

    logic                 keep, zero_area, accept;
    logic [XW-1:0]        minx, maxx;
    logic [YW-1:0]        miny, maxy;
    logic signed [EW-1:0] area;
    logic signed [EW-1:0] e_init [3];
    logic signed [EW-1:0] step_x [3];
    logic signed [EW-1:0] step_y [3];

    assign accept = in_valid && in_ready;

    tri_raster_setup #(.VW(VW), .SCR_W(SCR_W), .SCR_H(SCR_H), .EW(EW), .XW(XW), .YW(YW)) u_setup (
        .ax(in_ax), .ay(in_ay), .bx(in_bx), .by(in_by), .cx(in_cx), .cy(in_cy),
        .cull_neg(cull_neg), .keep(keep), .zero_area(zero_area),
        .minx(minx), .maxx(maxx), .miny(miny), .maxy(maxy), .area(area),
        .e_init(e_init), .step_x(step_x), .step_y(step_y)
    );

    tri_raster_walk #(.EW(EW), .XW(XW), .YW(YW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start(accept && keep), .drop(accept && !keep),
        .minx(minx), .maxx(maxx), .miny(miny), .maxy(maxy), .area(area),
        .e_init(e_init), .step_x(step_x), .step_y(step_y),
        .idle(in_ready),
        .frag_valid(out_valid), .frag_ready(out_ready),
        .frag_x(out_x), .frag_y(out_y), .frag_w0(out_w0), .frag_w1(out_w1),
        .done(tri_done)
    );

    p_zero_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && zero_area |=> in_ready && tri_done && !out_valid);
endmodule

// File: tb/tri_raster_test.sv
module tri_raster_test;
    localparam int VW = 12;
    localparam int SW = 32;
    localparam int SH = 32;
    localparam int EW = 2 * VW + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, cull_neg = 1'b0;
    logic signed [VW-1:0] in_ax = '0, in_ay = '0, in_bx = '0, in_by = '0, in_cx = '0, in_cy = '0;
    logic out_valid, out_ready = 1'b0, tri_done;
    logic [4:0] out_x, out_y;
    logic signed [EW-1:0] out_w0, out_w1;

    int n_checks = 0;
    int n_fail = 0;

    int    ex [1024];
    int    ey [1024];
    longint ew0 [1024];
    longint ew1 [1024];
    int    n_exp;

    always #10 clk = ~clk;

    tri_raster #(.VW(VW), .SCR_W(SW), .SCR_H(SH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ax(in_ax), .in_ay(in_ay), .in_bx(in_bx), .in_by(in_by), .in_cx(in_cx), .in_cy(in_cy),
        .cull_neg(cull_neg), .out_valid(out_valid), .out_ready(out_ready),
        .out_x(out_x), .out_y(out_y), .out_w0(out_w0), .out_w1(out_w1), .tri_done(tri_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint efn(input longint ux, uy, vx, vy, px, py);
        return (px - ux) * (vy - uy) - (py - uy) * (vx - ux);
    endfunction

    // Reference list built straight from the coverage rule (R2, R3, R4, R5, R7)
    task automatic build_ref(input int ax, ay, bx, by, cx, cy, input bit cull);
        longint ar;
        int sbx, sby, scx, scy, lx, hx, ly, hy;
        n_exp = 0;
        ar = efn(ax, ay, bx, by, cx, cy);
        if (ar == 0) return;
        if (ar < 0 && cull) return;
        sbx = bx; sby = by; scx = cx; scy = cy;
        if (ar < 0) begin sbx = cx; sby = cy; scx = bx; scy = by; end
        lx = ax; if (bx < lx) lx = bx; if (cx < lx) lx = cx;
        hx = ax; if (bx > hx) hx = bx; if (cx > hx) hx = cx;
        ly = ay; if (by < ly) ly = by; if (cy < ly) ly = cy;
        hy = ay; if (by > hy) hy = by; if (cy > hy) hy = cy;
        lx = lx >>> 4; hx = hx >>> 4; ly = ly >>> 4; hy = hy >>> 4;
        if (lx < 0) lx = 0; if (ly < 0) ly = 0;
        if (hx > SW - 1) hx = SW - 1; if (hy > SH - 1) hy = SH - 1;
        for (int y = ly; y <= hy; y++) begin
            for (int x = lx; x <= hx; x++) begin
                longint px, py, e0, e1, e2;
                px = x * 16 + 8; py = y * 16 + 8;
                e0 = efn(ax, ay, sbx, sby, px, py);
                e1 = efn(sbx, sby, scx, scy, px, py);
                e2 = efn(scx, scy, ax, ay, px, py);
                if (e0 > 0 && e1 > 0 && e2 > 0) begin
                    ex[n_exp] = x; ey[n_exp] = y; ew0[n_exp] = e1; ew1[n_exp] = e2;
                    n_exp++;
                end
            end
        end
    endtask

    task automatic run_tri(input string tag, input int ax, ay, bx, by, cx, cy,
                           input bit cull, input int stall_mod);
        int k, guard, cyc;
        bit hold, first;
        int hx, hy;
        longint hw0, hw1;
        build_ref(ax, ay, bx, by, cx, cy, cull);
        @(negedge clk);
        in_ax = VW'(ax); in_ay = VW'(ay); in_bx = VW'(bx);
        in_by = VW'(by); in_cx = VW'(cx); in_cy = VW'(cy);
        cull_neg = cull; in_valid = 1'b1;
        check(in_ready == 1'b1, {tag, " R9 in_ready before accept"}, longint'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        k = 0; guard = 0; cyc = 0; hold = 0; first = 1;
        forever begin
            out_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
            cyc++;
            #1;
            if (tri_done) break;
            if (first && n_exp > 0)
                check(in_ready == 1'b0, {tag, " R9 busy during walk"}, longint'(in_ready), 0);
            first = 0;
            if (hold) begin
                check(out_valid && out_x == hx && out_y == hy && out_w0 == hw0 && out_w1 == hw1,
                      {tag, " R8 fragment held under stall"}, longint'(out_x), longint'(hx));
            end
            hold = 0;
            if (out_valid && !out_ready) begin
                hold = 1; hx = out_x; hy = out_y; hw0 = out_w0; hw1 = out_w1;
            end
            if (out_valid && out_ready) begin
                if (k >= n_exp) begin
                    check(0, {tag, " R2 unexpected fragment"}, k + 1, n_exp);
                end else begin
                    check(out_x == ex[k] && out_y == ey[k], {tag, " R3 fragment position"},
                          longint'(out_y) * 100 + out_x, longint'(ey[k]) * 100 + ex[k]);
                    check(out_w0 == ew0[k] && out_w1 == ew1[k], {tag, " R4 weights"},
                          longint'(out_w0), ew0[k]);
                end
                k++;
            end
            guard++;
            if (guard > 20000) begin
                check(0, {tag, " watchdog expired"}, guard, 20000);
                break;
            end
            @(negedge clk);
        end
        check(k == n_exp, {tag, " R2 fragment count"}, k, n_exp);
        check(in_ready == 1'b1, {tag, " R9 idle at done"}, longint'(in_ready), 1);
        @(negedge clk);
        #1;
        check(tri_done == 1'b0, {tag, " R9 done is one cycle"}, longint'(tri_done), 0);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check(in_ready == 1'b1 && out_valid == 1'b0 && tri_done == 1'b0, "R1 reset state",
              longint'({in_ready, out_valid, tri_done}), 4);
    endtask

    task automatic t_basic;        // R2 R3 R4 positive winding, full ready
        run_tri("basic", 16, 16, 16, 176, 176, 16, 1'b0, 0);
    endtask

    task automatic t_fraction;     // R10 R8 fractional vertices, throttled consumer
        run_tri("fraction", 37, 21, 59, 230, 251, 93, 1'b0, 3);
    endtask

    task automatic t_on_edge;      // R2 centres lying on a vertical edge
        run_tri("on_edge", 136, 8, 136, 200, 300, 8, 1'b1, 0);
    endtask

    task automatic t_flip;         // R7 reversed winding, flip mode
        run_tri("flip", 16, 16, 176, 16, 16, 176, 1'b0, 2);
    endtask

    task automatic t_cull;         // R7 reversed winding, cull mode
        run_tri("cull", 16, 16, 176, 16, 16, 176, 1'b1, 0);
        check(n_exp == 0, "R7 cull reference empty", n_exp, 0);
    endtask

    task automatic t_zero;         // R6 collinear vertices
        run_tri("zero", 10, 10, 100, 100, 200, 200, 1'b0, 0);
    endtask

    task automatic t_clip;         // R5 triangle hanging past every side
        run_tri("clip", -100, -60, -40, 700, 650, 200, 1'b0, 0);
    endtask

    task automatic t_offscreen;    // R5 wholly beyond right edge
        run_tri("offscreen", 600, 10, 700, 200, 800, 20, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_fraction();
        t_on_edge();
        t_flip();
        t_cull();
        t_zero();
        t_clip();
        t_offscreen();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule